// File: doc/BRIEF.md
# Peripheral Interrupt Level Router

This block sits between a set of peripheral interrupt request lines and the core's event controller. Every source line carries a programmable 4-bit level field. The field steers the line onto one of seven general-purpose core priority levels, numbered 7 through 13. A per-source mask bit gates each line. A per-source wakeup-enable bit lets a line raise a wakeup indication even while it is masked. The block drives one request output per core level, raised while any active source is assigned to that level.

When the core takes a level, it asks the router which source caused it. It presents the level on the query port. One cycle later the router returns the lowest-numbered active source assigned to that level. If no such source exists, it returns a spurious flag and increments a spurious-event counter. Software reaches the configuration over a simple word-wide register port with combinational read data.

Top module: `sic_level_router`

## Requirements
- R1: Source n's level field occupies bits [(n mod 8)*4+3:(n mod 8)*4] of assignment register n/8, at word address n/8 (addresses 0 to 7 by default), and reads back as written.
- R2: A field value v in 0..6 routes the source to core level 7+v, which is bit v of `lvl_req`. Field values 7 to 15 route the source to no level.
- R3: A source is active only when its status bit and its mask bit are both 1. A masked source raises no level request.
- R4: The status bits copy `irq_in` at each clock edge, so a change shows one cycle later. They read at addresses 12 and 13, and writes to those addresses are ignored.
- R5: The mask and wakeup bits are held in banks of 32. Source n uses bit n mod 32 of bank n/32. Mask banks sit at addresses 8 and 9, and wakeup banks sit at addresses 10 and 11.
- R6: The cycle after `qry_valid` with level L, `rsp_valid` is 1 and `rsp_src` is the lowest-indexed active source whose field equals L-7.
- R7: If no active source is assigned to the queried level, or if L lies outside 7..13, the response has `rsp_spurious` = 1. In that case the spurious counter at address 14 increments by one. A hit leaves the counter unchanged.
- R8: Reset clears all mask bits, wakeup bits, level fields, status bits, the counter and the response. After reset no level request or wakeup is raised.
- R9: `wake_o` is 1 while any status bit is set whose wakeup enable is 1, whatever that source's mask bit is.
- R10: `rsp_valid` is 1 only in the cycle right after a cycle with `qry_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_in | input | 64 | Peripheral request lines, level sensitive |
| lvl_req | output | 7 | Request per core level; bit i is level 7+i |
| wake_o | output | 1 | Wakeup indication |
| qry_valid | input | 1 | Source query strobe |
| qry_level | input | 4 | Core level being serviced |
| rsp_valid | output | 1 | Query response valid |
| rsp_spurious | output | 1 | No active source found for the level |
| rsp_src | output | 6 | Index of the resolved source |

## Verification
The assertions take for granted that `qry_valid` and `qry_level` come from a synchronous master that changes them only between clock edges. They also assume that a query's response is judged against the configuration and status in place in the cycle of the query. The bench keeps within this by driving every input on the falling edge. It holds the configuration steady across each query and reads results one full cycle after the query. It changes assignments, masks and requests only through completed register writes, or whole-cycle changes of `irq_in`.

// File: rtl/sic_pkg.sv
package sic_pkg;

    localparam int LVL_BASE   = 7;
    localparam int NUM_LVL    = 7;
    localparam int FIELD_W    = 4;
    localparam int REG_W      = 32;
    localparam int FLD_PER_RG = REG_W / FIELD_W;
    localparam int BANK_W     = 32;
    localparam int SRC_W      = 8;

    typedef logic [FIELD_W-1:0] lvl_field_t;

    typedef enum logic [2:0] {
        RG_ASSIGN,
        RG_MASK,
        RG_WAKE,
        RG_STATUS,
        RG_COUNT,
        RG_NONE
    } reg_region_t;

    typedef struct packed {
        logic             valid;
        logic             spurious;
        logic [SRC_W-1:0] src;
    } qry_rsp_t;

    // Converts a core level number into a field code; flags out-of-range levels.
    function automatic logic level_in_range(input logic [FIELD_W-1:0] lvl);
        return (int'(lvl) >= LVL_BASE) && (int'(lvl) < LVL_BASE + NUM_LVL);
    endfunction

    function automatic lvl_field_t level_to_field(input logic [FIELD_W-1:0] lvl);
        return FIELD_W'(int'(lvl) - LVL_BASE);
    endfunction

endpackage

// File: rtl/sic_cfg_regs.sv
module sic_cfg_regs
    import sic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 5,
    parameter int CNT_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata,
    input  logic [NUM_SRC-1:0]       irq_in,
    input  logic [CNT_W-1:0]         spur_cnt,
    output logic [NUM_SRC*FIELD_W-1:0] fields,
    output logic [NUM_SRC-1:0]       mask_vec,
    output logic [NUM_SRC-1:0]       wake_vec,
    output logic [NUM_SRC-1:0]       status_vec
);

    localparam int NUM_AREG  = NUM_SRC / FLD_PER_RG;
    localparam int NUM_BANK  = NUM_SRC / BANK_W;
    localparam int MASK_BASE = NUM_AREG;
    localparam int WAKE_BASE = MASK_BASE + NUM_BANK;
    localparam int STAT_BASE = WAKE_BASE + NUM_BANK;
    localparam int CNT_ADDR  = STAT_BASE + NUM_BANK;

    logic [REG_W-1:0] assign_q [NUM_AREG];
    logic [REG_W-1:0] mask_q   [NUM_BANK];
    logic [REG_W-1:0] wake_q   [NUM_BANK];
    logic [NUM_SRC-1:0] status_q;

    reg_region_t region;

    always_comb begin
        region = RG_NONE;
        if (int'(reg_addr) < MASK_BASE)      region = RG_ASSIGN;
        else if (int'(reg_addr) < WAKE_BASE) region = RG_MASK;
        else if (int'(reg_addr) < STAT_BASE) region = RG_WAKE;
        else if (int'(reg_addr) < CNT_ADDR)  region = RG_STATUS;
        else if (int'(reg_addr) == CNT_ADDR) region = RG_COUNT;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_AREG; gi++) begin : g_areg
            always_ff @(posedge clk) begin
                if (rst)
                    assign_q[gi] <= '0;
                else if (reg_we && region == RG_ASSIGN && reg_addr == ADDR_W'(gi))
                    assign_q[gi] <= reg_wdata;
            end
        end
        for (gi = 0; gi < NUM_BANK; gi++) begin : g_bank
            always_ff @(posedge clk) begin
                if (rst) begin
                    mask_q[gi] <= '0;
                    wake_q[gi] <= '0;
                end else if (reg_we) begin
                    if (region == RG_MASK && reg_addr == ADDR_W'(MASK_BASE + gi))
                        mask_q[gi] <= reg_wdata;
                    if (region == RG_WAKE && reg_addr == ADDR_W'(WAKE_BASE + gi))
                        wake_q[gi] <= reg_wdata;
                end
            end
        end
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
            assign fields[gi*FIELD_W +: FIELD_W] =
                assign_q[gi / FLD_PER_RG][(gi % FLD_PER_RG)*FIELD_W +: FIELD_W];
            assign mask_vec[gi] = mask_q[gi / BANK_W][gi % BANK_W];
            assign wake_vec[gi] = wake_q[gi / BANK_W][gi % BANK_W];
        end
    endgenerate

    // Status is sampled from the request lines and never written by software.
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= irq_in;
    end
    assign status_vec = status_q;

    always_comb begin
        reg_rdata = '0;
        case (region)
            RG_ASSIGN: begin
                for (int i = 0; i < NUM_AREG; i++)
                    if (reg_addr == ADDR_W'(i)) reg_rdata = assign_q[i];
            end
            RG_MASK: begin
                for (int i = 0; i < NUM_BANK; i++)
                    if (reg_addr == ADDR_W'(MASK_BASE + i)) reg_rdata = mask_q[i];
            end
            RG_WAKE: begin
                for (int i = 0; i < NUM_BANK; i++)
                    if (reg_addr == ADDR_W'(WAKE_BASE + i)) reg_rdata = wake_q[i];
            end
            RG_STATUS: begin
                for (int i = 0; i < NUM_BANK; i++)
                    if (reg_addr == ADDR_W'(STAT_BASE + i))
                        reg_rdata = status_q[i*BANK_W +: BANK_W];
            end
            RG_COUNT: reg_rdata = REG_W'(spur_cnt);
            default:  reg_rdata = '0;
        endcase
    end

    AST_CFG_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (mask_vec == '0 && wake_vec == '0 && status_vec == '0)); // R8

endmodule

// File: rtl/sic_level_map.sv
module sic_level_map
    import sic_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SRC*FIELD_W-1:0] fields,
    input  logic [NUM_SRC-1:0]         status_vec,
    input  logic [NUM_SRC-1:0]         mask_vec,
    input  logic [NUM_SRC-1:0]         wake_vec,
    output logic [NUM_SRC-1:0]         active,
    output logic [NUM_LVL-1:0]         lvl_req,
    output logic                       wake_o
);

    assign active = status_vec & mask_vec;

    genvar gl, gs;
    generate
        for (gl = 0; gl < NUM_LVL; gl++) begin : g_lvl
            logic [NUM_SRC-1:0] member;
            for (gs = 0; gs < NUM_SRC; gs++) begin : g_mem
                assign member[gs] = (fields[gs*FIELD_W +: FIELD_W] == FIELD_W'(gl));
            end
            assign lvl_req[gl] = |(member & active);
        end
    endgenerate

    assign wake_o = |(status_vec & wake_vec);

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mask_vec == '0) |-> (lvl_req == '0)); // R3

endmodule

// File: rtl/sic_level_query.sv
module sic_level_query
    import sic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int CNT_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       qry_valid,
    input  logic [FIELD_W-1:0]         qry_level,
    input  logic [NUM_SRC-1:0]         active,
    input  logic [NUM_SRC*FIELD_W-1:0] fields,
    output qry_rsp_t                   rsp,
    output logic [CNT_W-1:0]           spur_cnt
);

    logic [NUM_SRC-1:0] cand;
    logic               lvl_ok;
    lvl_field_t         want;
    logic               found;
    logic [SRC_W-1:0]   hit_idx;

    assign lvl_ok = level_in_range(qry_level);
    assign want   = level_to_field(qry_level);

    genvar gs;
    generate
        for (gs = 0; gs < NUM_SRC; gs++) begin : g_cand
            assign cand[gs] = lvl_ok && active[gs] &&
                              (fields[gs*FIELD_W +: FIELD_W] == want);
        end
    endgenerate

    // Lowest index wins: scan downward so the last hit kept is the smallest.
    always_comb begin
        found   = 1'b0;
        hit_idx = '0;
        for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (cand[n]) begin
                found   = 1'b1;
                hit_idx = SRC_W'(n);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp      <= '0;
            spur_cnt <= '0;
        end else begin
            rsp.valid    <= qry_valid;
            rsp.spurious <= qry_valid && !found;
            rsp.src      <= found ? hit_idx : '0;
            if (qry_valid && !found)
                spur_cnt <= spur_cnt + 1'b1;
        end
    end

    AST_RSP_AFTER_QRY: assert property (@(posedge clk) disable iff (rst)
        qry_valid |=> rsp.valid); // R6

    AST_RSP_ONLY_AFTER_QRY: assert property (@(posedge clk) disable iff (rst)
        !qry_valid |=> !rsp.valid); // R10

    AST_SPUR_COUNTS: assert property (@(posedge clk) disable iff (rst)
        (rsp.valid && rsp.spurious) |-> (spur_cnt == CNT_W'($past(spur_cnt) + 1'b1))); // R7

    AST_HIT_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (rsp.valid && !rsp.spurious) |-> $stable(spur_cnt)); // R7

endmodule

// File: rtl/sic_level_router.sv
module sic_level_router
    import sic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 5,
    parameter int CNT_W   = 16,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_SRC-1:0] irq_in,
    output logic [6:0]         lvl_req,
    output logic               wake_o,
    input  logic               qry_valid,
    input  logic [3:0]         qry_level,
    output logic               rsp_valid,
    output logic               rsp_spurious,
    output logic [IDX_W-1:0]   rsp_src
);

    logic [NUM_SRC*FIELD_W-1:0] fields;
    logic [NUM_SRC-1:0]         mask_vec;
    logic [NUM_SRC-1:0]         wake_vec;
    logic [NUM_SRC-1:0]         status_vec;
    logic [NUM_SRC-1:0]         active;
    logic [CNT_W-1:0]           spur_cnt;
    qry_rsp_t                   rsp;

    sic_cfg_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_in     (irq_in),
        .spur_cnt   (spur_cnt),
        .fields     (fields),
        .mask_vec   (mask_vec),
        .wake_vec   (wake_vec),
        .status_vec (status_vec)
    );

    sic_level_map #(.NUM_SRC(NUM_SRC)) u_map (
        .clk        (clk),
        .rst        (rst),
        .fields     (fields),
        .status_vec (status_vec),
        .mask_vec   (mask_vec),
        .wake_vec   (wake_vec),
        .active     (active),
        .lvl_req    (lvl_req),
        .wake_o     (wake_o)
    );

    sic_level_query #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_query (
        .clk       (clk),
        .rst       (rst),
        .qry_valid (qry_valid),
        .qry_level (qry_level),
        .active    (active),
        .fields    (fields),
        .rsp       (rsp),
        .spur_cnt  (spur_cnt)
    );

    assign rsp_valid    = rsp.valid;
    assign rsp_spurious = rsp.spurious;
    assign rsp_src      = rsp.src[IDX_W-1:0];

    AST_WAKE_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        (|(irq_in & wake_vec) && $stable(wake_vec) && mask_vec == '0) |=> wake_o); // R9

endmodule

// File: tb/sic_level_router_bench.sv
module sic_level_router_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [4:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [63:0] irq_in;
    logic [6:0]  lvl_req;
    logic        wake_o;
    logic        qry_valid;
    logic [3:0]  qry_level;
    logic        rsp_valid;
    logic        rsp_spurious;
    logic [5:0]  rsp_src;

    int checks = 0;
    int errors = 0;
    logic [31:0] sh_as   [8];
    logic [31:0] sh_mask [2];
    logic [31:0] sh_wake [2];

    always #5 clk = ~clk;

    sic_level_router u_sic_level_router (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .lvl_req(lvl_req), .wake_o(wake_o), .qry_valid(qry_valid),
        .qry_level(qry_level), .rsp_valid(rsp_valid),
        .rsp_spurious(rsp_spurious), .rsp_src(rsp_src)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 5'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic set_field(input int n, input logic [3:0] v);
        sh_as[n/8][(n%8)*4 +: 4] = v;
        wr(n/8, sh_as[n/8]);
    endtask

    task automatic set_mask(input int n, input logic b);
        sh_mask[n/32][n%32] = b;
        wr(8 + n/32, sh_mask[n/32]);
    endtask

    task automatic set_wake(input int n, input logic b);
        sh_wake[n/32][n%32] = b;
        wr(10 + n/32, sh_wake[n/32]);
    endtask

    task automatic park_all();
        for (int i = 0; i < 8; i++) begin
            sh_as[i] = 32'h7777_7777;
            wr(i, sh_as[i]);
        end
    endtask

    task automatic query(input logic [3:0] lvl, output logic v, output logic sp,
                         output logic [5:0] src);
        qry_valid = 1'b1; qry_level = lvl;
        step();
        v = rsp_valid; sp = rsp_spurious; src = rsp_src;
        qry_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        for (int i = 0; i < 8; i++) sh_as[i] = '0;
        for (int i = 0; i < 2; i++) begin sh_mask[i] = '0; sh_wake[i] = '0; end
    endtask

    task automatic test_reset();
        logic [31:0] d;
        irq_in = '1;
        step();
        check("R8 lvl_req after reset", 32'(lvl_req), 32'h0);
        check("R8 wake after reset", 32'(wake_o), 32'h0);
        check("R8 rsp_valid after reset", 32'(rsp_valid), 32'h0);
        rd(8, d);  check("R8 mask bank0", d, 32'h0);
        rd(11, d); check("R8 wake bank1", d, 32'h0);
        rd(3, d);  check("R8 assign reg3", d, 32'h0);
        rd(14, d); check("R8 spurious count", d, 32'h0);
        irq_in = '0;
        step();
    endtask

    task automatic test_assign_layout();
        logic [31:0] d;
        sh_as[3] = 32'h8765_4321;
        wr(3, sh_as[3]);
        rd(3, d); check("R1 assign readback", d, 32'h8765_4321);
        set_field(29, 4'h5);
        rd(3, d); check("R1 source 29 nibble 5 of reg 3", d, 32'h8755_4321);
        set_field(2, 4'hC);
        rd(0, d); check("R1 source 2 nibble 2 of reg 0", d, 32'h0000_0C00);
        park_all();
    endtask

    task automatic test_level_routing();
        irq_in = '0; irq_in[40] = 1'b1;
        set_mask(40, 1'b1);
        set_field(40, 4'd3);
        check("R2 field 3 -> level 10", 32'(lvl_req), 32'h08);
        set_field(40, 4'd6);
        check("R2 field 6 -> level 13", 32'(lvl_req), 32'h40);
        set_field(40, 4'd0);
        check("R2 field 0 -> level 7", 32'(lvl_req), 32'h01);
        set_field(40, 4'd9);
        check("R2 field 9 routes nowhere", 32'(lvl_req), 32'h00);
        set_field(40, 4'd7);
        check("R2 field 7 routes nowhere", 32'(lvl_req), 32'h00);
    endtask

    task automatic test_mask_gating();
        logic [31:0] d;
        set_field(40, 4'd1);
        check("R3 unmasked source raises level 8", 32'(lvl_req), 32'h02);
        set_mask(40, 1'b0);
        check("R3 masked source silent", 32'(lvl_req), 32'h00);
        rd(13, d); check("R3 status still set while masked", d, 32'h0000_0100);
        set_field(40, 4'd7);
        irq_in = '0;
        step();
    endtask

    task automatic test_status_path();
        logic [31:0] d;
        irq_in[35] = 1'b1;
        rd(13, d); check("R4 status not yet captured", d, 32'h0);
        step();
        rd(13, d); check("R4 status bank1 bit3", d, 32'h0000_0008);
        rd(12, d); check("R4 status bank0 empty", d, 32'h0);
        wr(13, 32'hFFFF_FFFF);
        rd(13, d); check("R4 status write ignored", d, 32'h0000_0008);
        irq_in = '0;
        step();
        rd(13, d); check("R4 status follows release", d, 32'h0);
    endtask

    task automatic test_banks();
        logic [31:0] d;
        set_mask(37, 1'b1);
        rd(9, d); check("R5 mask bank1 bit5", d, 32'h0000_0020);
        rd(8, d); check("R5 mask bank0 untouched", d, 32'h0);
        set_field(37, 4'd2);
        irq_in[37] = 1'b1;
        step();
        check("R5 bank1 source 37 reaches level 9", 32'(lvl_req), 32'h04);
        set_wake(12, 1'b1);
        rd(10, d); check("R5 wake bank0 bit12", d, 32'h0000_1000);
        set_wake(12, 1'b0);
        set_mask(37, 1'b0); set_field(37, 4'd7);
        irq_in = '0;
        step();
    endtask

    task automatic test_query_order();
        logic v, sp; logic [5:0] s;
        set_field(5, 4'd2);  set_field(17, 4'd2); set_field(33, 4'd2);
        set_field(3, 4'd4);
        set_mask(5, 1'b1); set_mask(17, 1'b1); set_mask(33, 1'b1); set_mask(3, 1'b1);
        irq_in = '0;
        irq_in[5] = 1'b1; irq_in[17] = 1'b1; irq_in[33] = 1'b1; irq_in[3] = 1'b1;
        step();
        query(4'd9, v, sp, s);
        check("R6 rsp_valid", 32'(v), 32'h1);
        check("R6 level 9 lowest is 5", 32'(s), 32'd5);
        check("R6 level 9 not spurious", 32'(sp), 32'h0);
        query(4'd11, v, sp, s);
        check("R6 level 11 resolves 3", 32'(s), 32'd3);
        set_mask(5, 1'b0);
        query(4'd9, v, sp, s);
        check("R6 masked 5 skipped, 17 next", 32'(s), 32'd17);
        irq_in[17] = 1'b0;
        step();
        query(4'd9, v, sp, s);
        check("R6 bank1 source 33", 32'(s), 32'd33);
    endtask

    task automatic test_spurious();
        logic v, sp; logic [5:0] s; logic [31:0] c0, c1;
        rd(14, c0);
        query(4'd9, v, sp, s);
        rd(14, c1); check("R7 hit leaves counter", c1, c0);
        query(4'd13, v, sp, s);
        check("R7 empty level spurious", 32'(sp), 32'h1);
        rd(14, c1); check("R7 counter +1", c1, c0 + 1);
        query(4'd5, v, sp, s);
        check("R7 level 5 out of range spurious", 32'(sp), 32'h1);
        rd(14, c1); check("R7 counter +2", c1, c0 + 2);
        set_mask(33, 1'b0);
        query(4'd9, v, sp, s);
        check("R7 masked-only level spurious", 32'(sp), 32'h1);
        step();
        check("R10 no response without query", 32'(rsp_valid), 32'h0);
    endtask

    task automatic test_wake();
        for (int i = 0; i < 2; i++) begin sh_mask[i] = '0; wr(8 + i, '0); end
        irq_in = '0; irq_in[50] = 1'b1;
        step();
        check("R9 no wake without enable", 32'(wake_o), 32'h0);
        set_wake(50, 1'b1);
        check("R9 masked source wakes", 32'(wake_o), 32'h1);
        check("R9 no level while masked", 32'(lvl_req), 32'h0);
        set_wake(50, 1'b0);
        check("R9 wake drops", 32'(wake_o), 32'h0);
        irq_in = '0;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        irq_in = '0; qry_valid = 1'b0; qry_level = '0;
        @(negedge clk);
        do_reset();
        test_reset();
        test_assign_layout();
        test_level_routing();
        test_mask_gating();
        test_status_path();
        test_banks();
        test_query_order();
        test_spurious();
        test_wake();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule